// File: doc/BRIEF.md
# Resumable NMI trap controller

This block is the machine-mode control unit that lets a RISC-V hart take a non-maskable interrupt and later return from it. It owns four NMI control registers: a scratch word, the saved PC, the cause word and the status word. It answers CSR reads and writes by 12-bit address. At each instruction boundary it samples a level NMI request. When an NMI is taken, it saves the interrupted PC and privilege, clears its NMI enable and sends fetch to a fixed interrupt vector.

It also recognises the NMI-return instruction. That instruction restores the saved privilege, sets the enable again and jumps back to the saved PC. While the enable is clear, NMIs are blocked. In that state the unit also sends machine-mode traps to a separate exception vector and stops the modify-privilege bit from changing the privilege of loads and stores.

The pipeline around the block feeds it the current privilege, PC, instruction word and the relevant mstatus fields. It acts on the redirect, privilege-update, MPRV-clear and reservation-cancel outputs in the same cycle they are raised.

Top module: `rnmi_ctrl`

## Requirements
- R1: After reset, the scratch word and the saved PC read as 0 and the status word reads as 0, so the enable (bit 3) is clear. The cause word reads 0x80000000: the interrupt flag (bit XLEN-1) is 1 and the cause field is 0.
- R2: In Machine mode (privilege code 3), the addresses 0x740 (scratch), 0x741 (saved PC), 0x742 (cause) and 0x744 (status) raise csr_hit_o and read their register. Any other address gives csr_hit_o = 0 and read data 0.
- R3: An access to any of the four addresses from a privilege below Machine raises csr_illegal_o and returns read data 0. A write in that case changes nothing.
- R4: The status word holds the previous privilege in bits 12:11 and the enable in bit 3. Every other bit, including the virtualization bit 7, reads 0. A write can set the enable but cannot clear it.
- R5: A write to status bits 12:11 stores the code given when it names a supported privilege (0, 1 or 3). Code 2 stores 0, the lowest supported privilege.
- R6: The saved PC is kept and read with bit 0 forced to 0, for 16-bit instruction alignment. The return target is masked the same way.
- R7: A write to the cause word changes only bits XLEN-2:0. The interrupt flag stays as it was.
- R8: An NMI is taken only when at_boundary_i and nmi_req_i are both high and the enable is 1. In that cycle take_nmi_o, redirect_o, priv_update_o and cancel_resv_o are 1, redirect_pc_o holds the interrupt vector and new_priv_o is 3.
- R9: After an NMI is taken, the saved PC holds pc_i and status bits 12:11 hold priv_i from that cycle. The enable is 0 and the cause field is 0.
- R10: The word 0x70200073 with insn_valid_i high in Machine mode raises mnret_o. In that cycle redirect_pc_o is the masked saved PC, new_priv_o is the saved privilege, cancel_resv_o is 1, and clear_mprv_o is 1 only if the saved privilege is not 3. After the return the enable is 1.
- R11: The same word outside Machine mode raises illegal_insn_o with no redirect and no change to any state.
- R12: When trap_to_m_i is 1, the enable is 0 and mstatus_mpp_i is 3, exc_vec_o is the NMI exception vector. Otherwise exc_vec_o is mtvec_i.
- R13: eff_priv_o is mstatus_mpp_i only when mstatus_mprv_i is 1 and the enable is 1. Otherwise it is priv_i.
- R14: A taken NMI overrides an NMI return or a CSR write offered in the same cycle. The return does not fire and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| pc_i | input | XLEN | PC of the instruction at the boundary |
| at_boundary_i | input | 1 | Instruction boundary, when the NMI request is sampled |
| nmi_req_i | input | 1 | Level NMI request |
| insn_valid_i | input | 1 | insn_i holds an instruction that is executing |
| insn_i | input | 32 | Instruction word |
| csr_valid_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | The CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| trap_to_m_i | input | 1 | A trap is being taken to Machine mode |
| mstatus_mpp_i | input | 2 | mstatus previous-privilege field |
| mstatus_mprv_i | input | 1 | mstatus modify-privilege bit |
| mtvec_i | input | XLEN | Ordinary machine trap vector |
| csr_hit_o | output | 1 | The address names one of the four registers |
| csr_illegal_o | output | 1 | Access to a register from below Machine mode |
| csr_rdata_o | output | XLEN | CSR read data |
| take_nmi_o | output | 1 | An NMI is taken this cycle |
| mnret_o | output | 1 | An NMI return executes this cycle |
| illegal_insn_o | output | 1 | NMI return attempted below Machine mode |
| redirect_o | output | 1 | Fetch redirect |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_update_o | output | 1 | Privilege changes to new_priv_o |
| new_priv_o | output | 2 | New privilege |
| clear_mprv_o | output | 1 | Clear mstatus.MPRV |
| cancel_resv_o | output | 1 | Cancel the load reservation |
| exc_vec_o | output | XLEN | Vector for a trap being taken |
| eff_priv_o | output | 2 | Effective privilege for loads and stores |

## Verification
The assertions assume that priv_i only takes the codes 0, 1 and 3, and that the pipeline presents at most one instruction effect per cycle. That effect is a CSR access, an NMI return or a boundary sample. The stimulus keeps to these rules. Each cycle it drives at most one CSR access or one return word, and it changes the privilege only through priv_i between cycles. The single deliberate overlap, an NMI arriving together with a return and a write, exercises the priority rule in R14.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam logic [11:0] ADDR_SCRATCH = 12'h740;
  localparam logic [11:0] ADDR_EPC     = 12'h741;
  localparam logic [11:0] ADDR_CAUSE   = 12'h742;
  localparam logic [11:0] ADDR_STATUS  = 12'h744;

  localparam logic [31:0] RESUME_WORD = 32'h7020_0073;

  localparam int ST_PP_LO = 11;
  localparam int ST_PP_HI = 12;
  localparam int ST_IE    = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE,
    SEL_STATUS
  } csr_sel_e;

  function automatic csr_sel_e decode_addr(logic [11:0] a);
    case (a)
      ADDR_SCRATCH: return SEL_SCRATCH;
      ADDR_EPC:     return SEL_EPC;
      ADDR_CAUSE:   return SEL_CAUSE;
      ADDR_STATUS:  return SEL_STATUS;
      default:      return SEL_NONE;
    endcase
  endfunction

  function automatic logic priv_supported(logic [1:0] p, bit has_u, bit has_s);
    case (p)
      PRIV_M:  return 1'b1;
      PRIV_S:  return has_s;
      PRIV_U:  return has_u;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] legal_pp(logic [1:0] p, bit has_u, bit has_s);
    if (priv_supported(p, has_u, has_s)) return p;
    return has_u ? PRIV_U : PRIV_M;
  endfunction

endpackage

// File: rtl/rnmi_csr_file.sv
module rnmi_csr_file
  import rnmi_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_U      = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter int ALIGN_LSBS = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     addr_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            entry_i,
  input  logic [XLEN-1:0] entry_pc_i,
  input  logic [1:0]      entry_priv_i,
  input  logic            resume_i,
  output logic [XLEN-1:0] rd_data_o,
  output logic            hit_o,
  output logic            nmie_o,
  output logic [1:0]      mnpp_o,
  output logic [XLEN-1:0] epc_o
);

  localparam logic [XLEN-1:0] PC_MASK = {{(XLEN-ALIGN_LSBS){1'b1}}, {ALIGN_LSBS{1'b0}}};

  logic [XLEN-1:0] scratch_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-2:0] cause_q;
  logic            cause_int_q;
  logic            nmie_q;
  logic [1:0]      mnpp_q;
  csr_sel_e        sel;

  assign sel    = decode_addr(addr_i);
  assign hit_o  = (sel != SEL_NONE);
  assign nmie_o = nmie_q;
  assign mnpp_o = mnpp_q;
  assign epc_o  = epc_q & PC_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q   <= '0;
      epc_q       <= '0;
      cause_q     <= '0;
      cause_int_q <= 1'b1;
      nmie_q      <= 1'b0;
      mnpp_q      <= 2'b00;
    end else if (entry_i) begin
      epc_q   <= entry_pc_i;
      mnpp_q  <= entry_priv_i;
      nmie_q  <= 1'b0;
      cause_q <= '0;
    end else if (resume_i) begin
      nmie_q <= 1'b1;
    end else if (wr_en_i) begin
      case (sel)
        SEL_SCRATCH: scratch_q <= wr_data_i;
        SEL_EPC:     epc_q     <= wr_data_i & PC_MASK;
        SEL_CAUSE:   cause_q   <= wr_data_i[XLEN-2:0];
        SEL_STATUS: begin
          nmie_q <= nmie_q | wr_data_i[ST_IE];
          mnpp_q <= legal_pp(wr_data_i[ST_PP_HI:ST_PP_LO], HAS_U, HAS_S);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (sel)
      SEL_SCRATCH: rd_data_o = scratch_q;
      SEL_EPC:     rd_data_o = epc_q & PC_MASK;
      SEL_CAUSE:   rd_data_o = {cause_int_q, cause_q};
      SEL_STATUS: begin
        rd_data_o[ST_PP_HI:ST_PP_LO] = mnpp_q;
        rd_data_o[ST_IE]             = nmie_q;
      end
      default: ;
    endcase
  end

  // R4
  nmie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmie_q && !entry_i |=> nmie_q);

  // R9
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> !nmie_q && epc_q == $past(entry_pc_i) && mnpp_q == $past(entry_priv_i)
                && cause_q == '0);

endmodule

// File: rtl/rnmi_ret_decode.sv
module rnmi_ret_decode
  import rnmi_pkg::*;
(
  input  logic        insn_valid_i,
  input  logic [31:0] insn_i,
  input  logic [1:0]  priv_i,
  input  logic        blocked_i,
  output logic        fire_o,
  output logic        illegal_o
);

  logic is_resume;

  assign is_resume = insn_valid_i && !blocked_i && (insn_i == RESUME_WORD);
  assign fire_o    = is_resume && (priv_i == PRIV_M);
  assign illegal_o = is_resume && (priv_i != PRIV_M);

endmodule

// File: rtl/rnmi_priv_route.sv
module rnmi_priv_route
  import rnmi_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] EXC_VEC = '0
) (
  input  logic            nmie_i,
  input  logic            trap_to_m_i,
  input  logic [1:0]      mpp_i,
  input  logic            mprv_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic [XLEN-1:0] exc_vec_o,
  output logic [1:0]      eff_priv_o
);

  logic use_nmi_vec;

  assign use_nmi_vec = trap_to_m_i && !nmie_i && (mpp_i == PRIV_M);
  assign exc_vec_o   = use_nmi_vec ? EXC_VEC : mtvec_i;
  assign eff_priv_o  = (mprv_i && nmie_i) ? mpp_i : priv_i;

endmodule

// File: rtl/rnmi_ctrl.sv
module rnmi_ctrl
  import rnmi_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter bit              HAS_U       = 1'b1,
  parameter bit              HAS_S       = 1'b1,
  parameter bit              COMPRESSED  = 1'b1,
  parameter logic [XLEN-1:0] NMI_INT_VEC = XLEN'(32'h0000_0100),
  parameter logic [XLEN-1:0] NMI_EXC_VEC = XLEN'(32'h0000_0200)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            at_boundary_i,
  input  logic            nmi_req_i,
  input  logic            insn_valid_i,
  input  logic [31:0]     insn_i,
  input  logic            csr_valid_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            trap_to_m_i,
  input  logic [1:0]      mstatus_mpp_i,
  input  logic            mstatus_mprv_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic            csr_hit_o,
  output logic            csr_illegal_o,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            take_nmi_o,
  output logic            mnret_o,
  output logic            illegal_insn_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            priv_update_o,
  output logic [1:0]      new_priv_o,
  output logic            clear_mprv_o,
  output logic            cancel_resv_o,
  output logic [XLEN-1:0] exc_vec_o,
  output logic [1:0]      eff_priv_o
);

  localparam int ALIGN_LSBS = COMPRESSED ? 1 : 2;

  logic            nmie;
  logic [1:0]      mnpp;
  logic [XLEN-1:0] epc;
  logic [XLEN-1:0] rd_data;
  logic            addr_hit;
  logic            csr_m_ok;
  logic            csr_wr_en;

  assign take_nmi_o    = at_boundary_i && nmi_req_i && nmie;
  assign csr_hit_o     = csr_valid_i && addr_hit;
  assign csr_illegal_o = csr_hit_o && (priv_i != PRIV_M);
  assign csr_m_ok      = csr_hit_o && (priv_i == PRIV_M);
  assign csr_rdata_o   = csr_m_ok ? rd_data : '0;
  assign csr_wr_en     = csr_m_ok && csr_we_i && !take_nmi_o && !mnret_o;

  rnmi_csr_file #(
    .XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S), .ALIGN_LSBS(ALIGN_LSBS)
  ) u_csr (
    .clk(clk), .rst_n(rst_n),
    .addr_i(csr_addr_i), .wr_en_i(csr_wr_en), .wr_data_i(csr_wdata_i),
    .entry_i(take_nmi_o), .entry_pc_i(pc_i), .entry_priv_i(priv_i),
    .resume_i(mnret_o),
    .rd_data_o(rd_data), .hit_o(addr_hit), .nmie_o(nmie), .mnpp_o(mnpp), .epc_o(epc)
  );

  rnmi_ret_decode u_dec (
    .insn_valid_i(insn_valid_i), .insn_i(insn_i), .priv_i(priv_i),
    .blocked_i(take_nmi_o), .fire_o(mnret_o), .illegal_o(illegal_insn_o)
  );

  rnmi_priv_route #(.XLEN(XLEN), .EXC_VEC(NMI_EXC_VEC)) u_route (
    .nmie_i(nmie), .trap_to_m_i(trap_to_m_i), .mpp_i(mstatus_mpp_i),
    .mprv_i(mstatus_mprv_i), .priv_i(priv_i), .mtvec_i(mtvec_i),
    .exc_vec_o(exc_vec_o), .eff_priv_o(eff_priv_o)
  );

  assign redirect_o    = take_nmi_o || mnret_o;
  assign redirect_pc_o = take_nmi_o ? NMI_INT_VEC : epc;
  assign priv_update_o = redirect_o;
  assign new_priv_o    = take_nmi_o ? PRIV_M : mnpp;
  assign clear_mprv_o  = mnret_o && (mnpp != PRIV_M);
  assign cancel_resv_o = redirect_o;

  // R8
  nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> at_boundary_i && nmi_req_i);

  // R10
  resume_sets_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mnret_o |=> nmie);

  // R14
  nmi_over_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> !mnret_o && !illegal_insn_o);

  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_insn_o |-> !redirect_o && !priv_update_o);

  // R3
  csr_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal_o |-> csr_rdata_o == '0);

  // R13
  mprv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmie |-> eff_priv_o == priv_i);

endmodule

// File: tb/rnmi_ctrl_bench.sv
module rnmi_ctrl_bench;

  localparam int          XLEN = 32;
  localparam logic [31:0] INTV = 32'h0000_0100;
  localparam logic [31:0] EXCV = 32'h0000_0200;
  localparam logic [31:0] RETW = 32'h7020_0073;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      priv_i;
  logic [XLEN-1:0] pc_i;
  logic            at_boundary_i, nmi_req_i, insn_valid_i;
  logic [31:0]     insn_i;
  logic            csr_valid_i, csr_we_i;
  logic [11:0]     csr_addr_i;
  logic [XLEN-1:0] csr_wdata_i;
  logic            trap_to_m_i;
  logic [1:0]      mstatus_mpp_i;
  logic            mstatus_mprv_i;
  logic [XLEN-1:0] mtvec_i;
  logic            csr_hit_o, csr_illegal_o;
  logic [XLEN-1:0] csr_rdata_o;
  logic            take_nmi_o, mnret_o, illegal_insn_o, redirect_o;
  logic [XLEN-1:0] redirect_pc_o;
  logic            priv_update_o;
  logic [1:0]      new_priv_o;
  logic            clear_mprv_o, cancel_resv_o;
  logic [XLEN-1:0] exc_vec_o;
  logic [1:0]      eff_priv_o;

  rnmi_ctrl u_rnmi_ctrl (.*);

  always #10 clk = ~clk;

  int vec_cnt = 0;
  int bad_cnt = 0;

  logic [31:0] m_scr, m_epc, m_cause;
  logic        m_ie;
  logic [1:0]  m_pp;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    priv_i = 2'd3; pc_i = 32'h0000_1000;
    at_boundary_i = 0; nmi_req_i = 0; insn_valid_i = 0; insn_i = 32'h0000_0013;
    csr_valid_i = 0; csr_we_i = 0; csr_addr_i = 12'h000; csr_wdata_i = '0;
    trap_to_m_i = 0; mstatus_mpp_i = 2'd3; mstatus_mprv_i = 0; mtvec_i = 32'h0000_8000;
  endtask

  task automatic cyc(string req);
    bit take, is_ret, ret_ok, ret_bad, mapped, hit, in_m;
    logic [31:0] val, w;
    #2;
    take    = at_boundary_i && nmi_req_i && m_ie;
    is_ret  = insn_valid_i && insn_i == RETW && !take;
    ret_ok  = is_ret && priv_i == 2'd3;
    ret_bad = is_ret && priv_i != 2'd3;
    mapped  = csr_addr_i inside {12'h740, 12'h741, 12'h742, 12'h744};
    hit     = csr_valid_i && mapped;
    in_m    = hit && priv_i == 2'd3;
    case (csr_addr_i)
      12'h740: val = m_scr;
      12'h741: val = m_epc & 32'hFFFF_FFFE;
      12'h742: val = m_cause;
      12'h744: val = (32'(m_pp) << 11) | (32'(m_ie) << 3);
      default: val = 0;
    endcase
    chk(req, "csr_hit", 32'(csr_hit_o), 32'(hit));
    chk(req, "csr_illegal", 32'(csr_illegal_o), 32'(hit && priv_i != 2'd3));
    chk(req, "csr_rdata", csr_rdata_o, in_m ? val : 0);
    chk(req, "take_nmi", 32'(take_nmi_o), 32'(take));
    chk(req, "mnret", 32'(mnret_o), 32'(ret_ok));
    chk(req, "illegal_insn", 32'(illegal_insn_o), 32'(ret_bad));
    chk(req, "redirect", 32'(redirect_o), 32'(take || ret_ok));
    if (take) chk(req, "redirect_pc", redirect_pc_o, INTV);
    else if (ret_ok) chk(req, "redirect_pc", redirect_pc_o, m_epc & 32'hFFFF_FFFE);
    chk(req, "priv_update", 32'(priv_update_o), 32'(take || ret_ok));
    if (take) chk(req, "new_priv", 32'(new_priv_o), 32'd3);
    else if (ret_ok) chk(req, "new_priv", 32'(new_priv_o), 32'(m_pp));
    chk(req, "clear_mprv", 32'(clear_mprv_o), 32'(ret_ok && m_pp != 2'd3));
    chk(req, "cancel_resv", 32'(cancel_resv_o), 32'(take || ret_ok));
    chk(req, "exc_vec", exc_vec_o,
        (trap_to_m_i && !m_ie && mstatus_mpp_i == 2'd3) ? EXCV : mtvec_i);
    chk(req, "eff_priv", 32'(eff_priv_o),
        32'((mstatus_mprv_i && m_ie) ? mstatus_mpp_i : priv_i));
    @(posedge clk);
    w = csr_wdata_i;
    if (take) begin
      m_epc = pc_i; m_pp = priv_i; m_ie = 0; m_cause[30:0] = '0;
    end else if (ret_ok) begin
      m_ie = 1;
    end else if (in_m && csr_we_i) begin
      if (csr_addr_i == 12'h740) m_scr = w;
      if (csr_addr_i == 12'h741) m_epc = {w[31:1], 1'b0};
      if (csr_addr_i == 12'h742) m_cause = {m_cause[31], w[30:0]};
      if (csr_addr_i == 12'h744) begin
        if (w[3]) m_ie = 1;
        m_pp = (w[12:11] == 2'd2) ? 2'd0 : w[12:11];
      end
    end
    @(negedge clk);
  endtask

  task automatic rd(logic [11:0] a, string req);
    csr_valid_i = 1; csr_we_i = 0; csr_addr_i = a;
    cyc(req);
    idle();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string req);
    csr_valid_i = 1; csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d;
    cyc(req);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    bad_cnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_scr = 0; m_epc = 0; m_cause = 32'h8000_0000; m_ie = 0; m_pp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset values
    rd(12'h740, "R1"); rd(12'h741, "R1"); rd(12'h742, "R1"); rd(12'h744, "R1");

    // R12 / R13 with the enable clear
    trap_to_m_i = 1; cyc("R12");
    mstatus_mpp_i = 2'd0; cyc("R12");
    idle();
    mstatus_mprv_i = 1; mstatus_mpp_i = 2'd1; cyc("R13");
    idle();

    // R2: map and scratch
    wr(12'h740, 32'hDEAD_BEEF, "R2"); rd(12'h740, "R2");
    rd(12'h743, "R2"); rd(12'h745, "R2");

    // R3: lower privilege access
    priv_i = 2'd0; csr_valid_i = 1; csr_we_i = 1; csr_addr_i = 12'h740;
    csr_wdata_i = 32'h0000_1234; cyc("R3"); idle();
    priv_i = 2'd1; csr_valid_i = 1; csr_addr_i = 12'h744; cyc("R3"); idle();
    rd(12'h740, "R3");

    // R8: no NMI while the enable is clear
    at_boundary_i = 1; nmi_req_i = 1; cyc("R8"); idle();

    // R4: status set-only enable, other bits zero
    wr(12'h744, 32'hFFFF_FFFF, "R4"); rd(12'h744, "R4");
    wr(12'h744, 32'h0000_0000, "R4"); rd(12'h744, "R4");
    // R5: privilege legalization
    wr(12'h744, 32'h0000_1000, "R5"); rd(12'h744, "R5");
    wr(12'h744, 32'h0000_0800, "R5"); rd(12'h744, "R5");

    // R6: saved PC alignment
    wr(12'h741, 32'h0000_1235, "R6"); rd(12'h741, "R6");
    // R7: cause field only
    wr(12'h742, 32'h0000_0005, "R7"); rd(12'h742, "R7");
    wr(12'h742, 32'hFFFF_FFFF, "R7"); rd(12'h742, "R7");

    // R12 / R13 with the enable set
    trap_to_m_i = 1; cyc("R12"); idle();
    mstatus_mprv_i = 1; mstatus_mpp_i = 2'd1; cyc("R13"); idle();

    // R8: request without boundary, then taken from U mode
    nmi_req_i = 1; priv_i = 2'd0; cyc("R8");
    at_boundary_i = 1; pc_i = 32'h4000_0010; cyc("R8"); idle();
    // R9: saved state
    rd(12'h741, "R9"); rd(12'h742, "R9"); rd(12'h744, "R9");
    at_boundary_i = 1; nmi_req_i = 1; cyc("R9"); idle();

    // R11: return from U mode
    priv_i = 2'd0; insn_valid_i = 1; insn_i = RETW; cyc("R11"); idle();
    rd(12'h744, "R11");
    // R10: return to U
    insn_valid_i = 1; insn_i = RETW; cyc("R10"); idle();
    rd(12'h744, "R10");
    // R10: return with saved privilege M
    wr(12'h744, 32'h0000_1800, "R10");
    insn_valid_i = 1; insn_i = RETW; cyc("R10"); idle();
    insn_valid_i = 1; insn_i = 32'h3020_0073; cyc("R10"); idle();

    // R14: NMI beats return and CSR write in the same cycle
    at_boundary_i = 1; nmi_req_i = 1; insn_valid_i = 1; insn_i = RETW;
    csr_valid_i = 1; csr_we_i = 1; csr_addr_i = 12'h740; csr_wdata_i = 32'h5555_0000;
    pc_i = 32'h4000_0400; cyc("R14"); idle();
    rd(12'h740, "R14"); rd(12'h744, "R14"); rd(12'h741, "R14");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule